// File: doc/BRIEF.md
# Group Completion Tracking Table

This block keeps track of instruction groups in a four-thread core, from the cycle they are dispatched until they retire. The dispatch stage can send in one group per cycle. Each group carries a thread number and a six-bit mask that marks which of its instruction slots are occupied. The first four slots hold ordinary instructions and the last two hold branches. The table gives the group the lowest free entry, and the number of that entry is the group's tag. Execution units later report finished instructions by tag and slot on two finish ports.

A group retires once every occupied slot has finished and no older group of its own thread is still in the table. Retirement bandwidth is shared between two fixed thread pairs. Threads 0 and 2 form one pair and threads 1 and 3 form the other. Each pair reports at most one retiring group per cycle on its own completion port. When both threads of a pair are ready, the pair takes them in turn. Dispatch is stalled while the table is full or while a flush is being applied. A flush names a thread and one of its tags, and removes every group of that thread that is younger than the named group.

Top module: `group_retire_table`

## Requirements
- R1: After reset the table is empty: compValid is 0, dispStall is 0 and dispTag is 0.
- R2: While the table is not full, dispTag shows the lowest-numbered free entry. A dispatch with dispValid high and dispStall low writes the group into that entry at the next clock edge.
- R3: dispStall is high whenever all 20 entries are occupied or flushValid is high. A dispatch offered while dispStall is high is dropped and leaves the table unchanged.
- R4: A group is reported only after every slot marked 1 in its dispatch mask has been finished. Slot k of the mask is bit k. A finish on a slot that is not in the mask changes nothing, and a finish with a slot index of 6 or 7 is ignored.
- R5: Within a thread, groups retire in dispatch order. Only the oldest group of a thread still in the table can be reported.
- R6: Completion port 0 reports only threads 0 and 2, and port 1 reports only threads 1 and 3. Each port reports at most one group per cycle, so at most two groups retire per cycle.
- R7: A pair has one preference flag, which selects its higher-numbered thread when set and is cleared by reset. When both threads of a pair have a ready group, the pair takes the thread its flag selects. After every retirement on that pair, the flag is set to select the thread that did not retire.
- R8: Retirement outputs are combinational from the table state, so a group is reported in the cycle after its last finish edge. Its entry is freed at the edge that ends that cycle, and dispatch can reuse it in the cycle that follows.
- R9: A flush for thread T with tag G removes, in one edge, every group of thread T dispatched after G. Group G itself, older groups of T, and all groups of other threads stay in the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dispValid | input | 1 | A group is offered for dispatch |
| dispThread | input | 2 | Thread of the offered group |
| dispSlots | input | 6 | Occupied-slot mask; bits 0-3 are ordinary instructions and bits 4-5 are branches |
| dispStall | output | 1 | Dispatch is not accepted this cycle |
| dispTag | output | 5 | Entry the offered group will occupy |
| finValid | input | 2 | One valid bit per finish port |
| finTag | input | 10 | Group tag per finish port; port p uses bits [5p+4:5p] |
| finSlot | input | 6 | Slot index per finish port; port p uses bits [3p+2:3p] |
| flushValid | input | 1 | Flush request |
| flushThread | input | 2 | Thread to flush |
| flushTag | input | 5 | Youngest group of that thread that is kept |
| compValid | output | 2 | Retirement valid; bit 0 is pair {0,2} and bit 1 is pair {1,3} |
| compThread | output | 4 | Retiring thread per pair; pair p uses bits [2p+1:2p] |
| compTag | output | 10 | Retiring tag per pair; pair p uses bits [5p+4:5p] |

## Verification
Dispatch, finish and flush inputs all act at the next rising edge. The outputs dispStall, dispTag and the retirement ports are combinational from the stored state, so each of them reflects an input in the cycle after the edge that took that input. An entry that is reported as retiring is freed at the edge that ends the reporting cycle. The bench drives inputs just after the falling edge and reads outputs 1 ns later, comparing them with a reference model of the table kept in bench variables. It advances that model only once the rising edge has passed, so each check compares against the state the design has after all earlier edges.

// File: rtl/grt_pkg.sv
package grt_pkg;
  localparam int NUM_ENTRIES = 20;
  localparam int SLOTS       = 6;
  localparam int THREADS     = 4;
  localparam int PAIRS       = 2;
  localparam int FIN_PORTS   = 2;
  localparam int TAG_W       = $clog2(NUM_ENTRIES);
  localparam int SLOT_W      = $clog2(SLOTS);
  localparam int THR_W       = $clog2(THREADS);

  // strobes from control to storage
  typedef struct packed {
    logic                   allocEn;
    logic [TAG_W-1:0]       allocIdx;
    logic [NUM_ENTRIES-1:0] clearMask;
  } grtStrobes_t;
endpackage

// File: rtl/grt_store.sv
module grt_store
  import grt_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  grtStrobes_t                   strb,
  input  logic [THR_W-1:0]              dispThread,
  input  logic [SLOTS-1:0]              dispSlots,
  input  logic [FIN_PORTS-1:0]          finValid,
  input  logic [FIN_PORTS*TAG_W-1:0]    finTag,
  input  logic [FIN_PORTS*SLOT_W-1:0]   finSlot,
  input  logic [THR_W-1:0]              flushThread,
  input  logic [TAG_W-1:0]              flushTag,
  output logic [NUM_ENTRIES-1:0]        entValid,
  output logic [NUM_ENTRIES*THR_W-1:0]  entThread,
  output logic [NUM_ENTRIES-1:0]        entDone,
  output logic [NUM_ENTRIES-1:0]        entOldest,
  output logic [NUM_ENTRIES-1:0]        flushYounger
);
  logic [NUM_ENTRIES-1:0] validQ;
  logic [THR_W-1:0]       threadQ [NUM_ENTRIES];
  logic [SLOTS-1:0]       needQ   [NUM_ENTRIES];
  logic [SLOTS-1:0]       finQ    [NUM_ENTRIES];
  // olderQ[i][j] set: entry j was dispatched before entry i
  logic [NUM_ENTRIES-1:0] olderQ  [NUM_ENTRIES];
  logic [SLOTS-1:0]       finHit  [NUM_ENTRIES];

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      finHit[i] = '0;
      for (int p = 0; p < FIN_PORTS; p++) begin
        if (finValid[p] && finTag[p*TAG_W +: TAG_W] == TAG_W'(i) &&
            int'(finSlot[p*SLOT_W +: SLOT_W]) < SLOTS)
          finHit[i][finSlot[p*SLOT_W +: SLOT_W]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        threadQ[i] <= '0;
        needQ[i]   <= '0;
        finQ[i]    <= '0;
        olderQ[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strb.allocEn && strb.allocIdx == TAG_W'(i)) begin
          validQ[i]  <= 1'b1;
          threadQ[i] <= dispThread;
          needQ[i]   <= dispSlots;
          finQ[i]    <= '0;
          olderQ[i]  <= validQ & ~strb.clearMask;
        end else begin
          if (strb.clearMask[i]) validQ[i] <= 1'b0;
          finQ[i] <= finQ[i] | finHit[i];
          if (strb.allocEn) olderQ[i][strb.allocIdx] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      logic [NUM_ENTRIES-1:0] sameThr;
      for (int j = 0; j < NUM_ENTRIES; j++)
        sameThr[j] = validQ[j] && (threadQ[j] == threadQ[i]);
      entThread[i*THR_W +: THR_W] = threadQ[i];
      entDone[i]      = &(finQ[i] | ~needQ[i]);
      entOldest[i]    = validQ[i] && !(|(olderQ[i] & sameThr));
      flushYounger[i] = validQ[i] && (threadQ[i] == flushThread) &&
                        (int'(flushTag) < NUM_ENTRIES) && olderQ[i][flushTag];
    end
  end

  assign entValid = validQ;
endmodule

// File: rtl/grt_ctrl.sv
module grt_ctrl
  import grt_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          dispValid,
  input  logic                          flushValid,
  input  logic [NUM_ENTRIES-1:0]        entValid,
  input  logic [NUM_ENTRIES*THR_W-1:0]  entThread,
  input  logic [NUM_ENTRIES-1:0]        entDone,
  input  logic [NUM_ENTRIES-1:0]        entOldest,
  input  logic [NUM_ENTRIES-1:0]        flushYounger,
  output grtStrobes_t                   strb,
  output logic                          dispStall,
  output logic [TAG_W-1:0]              dispTag,
  output logic [PAIRS-1:0]              compValid,
  output logic [PAIRS*THR_W-1:0]        compThread,
  output logic [PAIRS*TAG_W-1:0]        compTag
);
  logic [TAG_W-1:0]       freeIdx;
  logic                   tableFull;
  logic [THREADS-1:0]     thrReady;
  logic [TAG_W-1:0]       thrTag [THREADS];
  logic [TAG_W-1:0]       pickTag [PAIRS];
  logic [NUM_ENTRIES-1:0] retireMask;

  // lowest free entry
  always_comb begin
    freeIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (!entValid[i]) freeIdx = TAG_W'(i);
  end
  assign tableFull = &entValid;
  assign dispStall = tableFull || flushValid;
  assign dispTag   = freeIdx;

  // at most one oldest entry per thread, so OR-ing the indices is exact
  always_comb begin
    for (int t = 0; t < THREADS; t++) begin
      thrReady[t] = 1'b0;
      thrTag[t]   = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (entValid[i] && entDone[i] && entOldest[i] &&
            entThread[i*THR_W +: THR_W] == THR_W'(t)) begin
          thrReady[t] = 1'b1;
          thrTag[t]   = thrTag[t] | TAG_W'(i);
        end
      end
    end
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int LO = p;
    localparam int HI = p + PAIRS;
    logic prefHiQ;
    logic pickHi;
    assign pickHi       = thrReady[HI] && (!thrReady[LO] || prefHiQ);
    assign compValid[p] = thrReady[LO] || thrReady[HI];
    assign compThread[p*THR_W +: THR_W] = pickHi ? THR_W'(HI) : THR_W'(LO);
    assign pickTag[p]   = pickHi ? thrTag[HI] : thrTag[LO];
    assign compTag[p*TAG_W +: TAG_W] = pickTag[p];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             prefHiQ <= 1'b0;
      else if (compValid[p]) prefHiQ <= !pickHi;
    end
  end

  always_comb begin
    retireMask = '0;
    for (int p = 0; p < PAIRS; p++)
      if (compValid[p]) retireMask[pickTag[p]] = 1'b1;
  end

  assign strb.allocEn   = dispValid && !dispStall;
  assign strb.allocIdx  = freeIdx;
  assign strb.clearMask = retireMask | (flushValid ? flushYounger : '0);
endmodule

// File: rtl/group_retire_table.sv
module group_retire_table
  import grt_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        dispValid,
  input  logic [THR_W-1:0]            dispThread,
  input  logic [SLOTS-1:0]            dispSlots,
  output logic                        dispStall,
  output logic [TAG_W-1:0]            dispTag,
  input  logic [FIN_PORTS-1:0]        finValid,
  input  logic [FIN_PORTS*TAG_W-1:0]  finTag,
  input  logic [FIN_PORTS*SLOT_W-1:0] finSlot,
  input  logic                        flushValid,
  input  logic [THR_W-1:0]            flushThread,
  input  logic [TAG_W-1:0]            flushTag,
  output logic [PAIRS-1:0]            compValid,
  output logic [PAIRS*THR_W-1:0]      compThread,
  output logic [PAIRS*TAG_W-1:0]      compTag
);
  grtStrobes_t                  strb;
  logic [NUM_ENTRIES-1:0]       entValid;
  logic [NUM_ENTRIES*THR_W-1:0] entThread;
  logic [NUM_ENTRIES-1:0]       entDone;
  logic [NUM_ENTRIES-1:0]       entOldest;
  logic [NUM_ENTRIES-1:0]       flushYounger;

  grt_store u_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .dispThread(dispThread), .dispSlots(dispSlots),
    .finValid(finValid), .finTag(finTag), .finSlot(finSlot),
    .flushThread(flushThread), .flushTag(flushTag),
    .entValid(entValid), .entThread(entThread), .entDone(entDone),
    .entOldest(entOldest), .flushYounger(flushYounger)
  );

  grt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .flushValid(flushValid),
    .entValid(entValid), .entThread(entThread), .entDone(entDone),
    .entOldest(entOldest), .flushYounger(flushYounger),
    .strb(strb), .dispStall(dispStall), .dispTag(dispTag),
    .compValid(compValid), .compThread(compThread), .compTag(compTag)
  );
endmodule

// File: rtl/grt_checker.sv
module grt_checker
  import grt_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     dispValid,
  input logic                     dispStall,
  input logic [TAG_W-1:0]         dispTag,
  input logic                     flushValid,
  input logic [PAIRS-1:0]         compValid,
  input logic [PAIRS*THR_W-1:0]   compThread,
  input logic [PAIRS*TAG_W-1:0]   compTag,
  input logic [NUM_ENTRIES-1:0]   entValid,
  input logic [NUM_ENTRIES-1:0]   entDone
);
  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !dispStall) |-> !entValid[dispTag]); // R2
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (&entValid) |-> dispStall); // R3
  AST_FLUSH_STALL: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> dispStall); // R3
  AST_DONE_PAIR0: assert property (@(posedge clk) disable iff (!rstN)
    compValid[0] |-> entDone[compTag[TAG_W-1:0]]); // R4
  AST_DONE_PAIR1: assert property (@(posedge clk) disable iff (!rstN)
    compValid[1] |-> entDone[compTag[2*TAG_W-1:TAG_W]]); // R4
  AST_PAIR0_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    compValid[0] |-> !compThread[0]); // R6
  AST_PAIR1_ODD: assert property (@(posedge clk) disable iff (!rstN)
    compValid[1] |-> compThread[THR_W]); // R6
  AST_TAGS_DISTINCT: assert property (@(posedge clk) disable iff (!rstN)
    (&compValid) |-> (compTag[TAG_W-1:0] != compTag[2*TAG_W-1:TAG_W])); // R6
  AST_FREED_PAIR0: assert property (@(posedge clk) disable iff (!rstN)
    compValid[0] |=> !entValid[$past(compTag[TAG_W-1:0])]); // R8
  AST_FREED_PAIR1: assert property (@(posedge clk) disable iff (!rstN)
    compValid[1] |=> !entValid[$past(compTag[2*TAG_W-1:TAG_W])]); // R8
endmodule

bind group_retire_table grt_checker u_chk (
  .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispStall(dispStall),
  .dispTag(dispTag), .flushValid(flushValid), .compValid(compValid),
  .compThread(compThread), .compTag(compTag), .entValid(entValid),
  .entDone(entDone)
);

// File: tb/group_retire_table_tb.sv
module group_retire_table_tb;
  import grt_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                        rstN;
  logic                        dispValid;
  logic [THR_W-1:0]            dispThread;
  logic [SLOTS-1:0]            dispSlots;
  logic                        dispStall;
  logic [TAG_W-1:0]            dispTag;
  logic [FIN_PORTS-1:0]        finValid;
  logic [FIN_PORTS*TAG_W-1:0]  finTag;
  logic [FIN_PORTS*SLOT_W-1:0] finSlot;
  logic                        flushValid;
  logic [THR_W-1:0]            flushThread;
  logic [TAG_W-1:0]            flushTag;
  logic [PAIRS-1:0]            compValid;
  logic [PAIRS*THR_W-1:0]      compThread;
  logic [PAIRS*TAG_W-1:0]      compTag;

  group_retire_table u_dut (.*);

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  // reference model
  bit         mValid [NUM_ENTRIES];
  int         mThr   [NUM_ENTRIES];
  bit [5:0]   mNeed  [NUM_ENTRIES];
  bit [5:0]   mFin   [NUM_ENTRIES];
  int         mSeq   [NUM_ENTRIES];
  bit         mPref  [PAIRS];
  int         pairRetired [PAIRS];
  int         seqCnt = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    dispValid = 0; dispThread = 0; dispSlots = 0;
    finValid = 0; finTag = 0; finSlot = 0;
    flushValid = 0; flushThread = 0; flushTag = 0;
  endtask

  task automatic setFin(int port, int tag, int slot);
    finValid[port] = 1'b1;
    finTag[port*TAG_W +: TAG_W] = TAG_W'(tag);
    finSlot[port*SLOT_W +: SLOT_W] = SLOT_W'(slot);
  endtask

  // inputs already driven after the falling edge: check, then advance model
  task automatic cycle();
    bit full;
    int freeIdx;
    int oldest [THREADS];
    bit rdy [THREADS];
    bit selV [PAIRS];
    int selT [PAIRS];
    bit kill [NUM_ENTRIES];
    int refSeq;
    #1;
    full = 1; freeIdx = -1;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (!mValid[i]) begin
        full = 0;
        if (freeIdx < 0) freeIdx = i;
      end
    chk(dispStall == (full | flushValid), "R3 stall", int'(dispStall), int'(full | flushValid));
    if (!full) chk(int'(dispTag) == freeIdx, "R2 R8 dispTag", int'(dispTag), freeIdx);
    for (int t = 0; t < THREADS; t++) begin
      oldest[t] = -1;
      for (int i = 0; i < NUM_ENTRIES; i++)
        if (mValid[i] && mThr[i] == t && (oldest[t] < 0 || mSeq[i] < mSeq[oldest[t]]))
          oldest[t] = i;
      rdy[t] = (oldest[t] >= 0) && ((mFin[oldest[t]] | ~mNeed[oldest[t]]) == 6'h3f);
    end
    for (int p = 0; p < PAIRS; p++) begin
      bit hi;
      hi = rdy[p+PAIRS] && (!rdy[p] || mPref[p]);
      selV[p] = rdy[p] || rdy[p+PAIRS];
      selT[p] = hi ? p + PAIRS : p;
      chk(compValid[p] == selV[p], "R4 R5 compValid", int'(compValid[p]), int'(selV[p]));
      if (selV[p] && compValid[p]) begin
        chk(int'(compThread[p*THR_W +: THR_W]) == selT[p], "R6 R7 compThread",
            int'(compThread[p*THR_W +: THR_W]), selT[p]);
        chk(int'(compTag[p*TAG_W +: TAG_W]) == oldest[selT[p]], "R5 R8 compTag",
            int'(compTag[p*TAG_W +: TAG_W]), oldest[selT[p]]);
      end
    end
    @(posedge clk);
    // flush set from the pre-edge state
    for (int i = 0; i < NUM_ENTRIES; i++) kill[i] = 0;
    if (flushValid) begin
      refSeq = mSeq[flushTag];
      for (int i = 0; i < NUM_ENTRIES; i++)
        kill[i] = mValid[i] && mThr[i] == int'(flushThread) && mSeq[i] > refSeq;
    end
    for (int f = 0; f < FIN_PORTS; f++) begin
      int tg, sl;
      tg = int'(finTag[f*TAG_W +: TAG_W]);
      sl = int'(finSlot[f*SLOT_W +: SLOT_W]);
      if (finValid[f] && sl < SLOTS && tg < NUM_ENTRIES) mFin[tg][sl] = 1'b1;
    end
    for (int p = 0; p < PAIRS; p++)
      if (selV[p]) begin
        mValid[oldest[selT[p]]] = 0;
        pairRetired[p]++;
        mPref[p] = (selT[p] == p);
      end
    for (int i = 0; i < NUM_ENTRIES; i++) if (kill[i]) mValid[i] = 0;
    if (dispValid && !(full || flushValid)) begin
      mValid[freeIdx] = 1; mThr[freeIdx] = int'(dispThread);
      mNeed[freeIdx] = dispSlots; mFin[freeIdx] = 0; mSeq[freeIdx] = seqCnt++;
    end
  endtask

  task automatic disp(int th, bit [5:0] s);
    @(negedge clk); idle();
    dispValid = 1; dispThread = THR_W'(th); dispSlots = s;
    cycle();
  endtask

  task automatic drain();
    for (int n = 0; n < 400; n++) begin
      bit any;
      int k;
      any = 0; k = 0;
      @(negedge clk); idle();
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        any |= mValid[i];
        for (int s = 0; s < SLOTS; s++)
          if (mValid[i] && mNeed[i][s] && !mFin[i][s] && k < FIN_PORTS) begin
            setFin(k, i, s); k++;
          end
      end
      cycle();
      if (!any) break;
    end
  endtask

  initial begin
    int base;
    void'($urandom(32'd20517));
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      mValid[i] = 0; mThr[i] = 0; mNeed[i] = 0; mFin[i] = 0; mSeq[i] = 0;
    end
    for (int p = 0; p < PAIRS; p++) begin mPref[p] = 0; pairRetired[p] = 0; end
    rstN = 0; idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    chk(compValid == '0, "R1 compValid", int'(compValid), 0);
    chk(dispStall == 1'b0, "R1 dispStall", int'(dispStall), 0);
    chk(dispTag == '0, "R1 dispTag", int'(dispTag), 0);

    // fill the table, then offer one more group while full (R3)
    for (int i = 0; i < NUM_ENTRIES; i++) disp(i % THREADS, 6'h01);
    disp(1, 6'h3f);
    @(negedge clk); idle(); #1;
    chk(dispStall == 1'b1, "R3 full stays full", int'(dispStall), 1);
    cycle();
    // finish on unmasked slot and out-of-range slot must not retire (R4)
    @(negedge clk); idle(); setFin(0, 0, 3); setFin(1, 0, 7); cycle();
    @(negedge clk); idle(); #1;
    chk(compValid[0] == 1'b0, "R4 unmasked finish", int'(compValid[0]), 0);
    cycle();
    drain();

    // round robin inside pair {0,2} (R7)
    disp(0, 6'h01); disp(2, 6'h01); disp(0, 6'h01); disp(2, 6'h01);
    @(negedge clk); idle(); setFin(0, 0, 0); setFin(1, 1, 0); cycle();
    @(negedge clk); idle(); setFin(0, 2, 0); setFin(1, 3, 0); cycle();
    repeat (5) begin @(negedge clk); idle(); cycle(); end
    drain();

    // flush of thread 1 keeps named group and thread 3 (R9)
    disp(1, 6'h01); disp(1, 6'h01); disp(1, 6'h01); disp(3, 6'h01);
    @(negedge clk); idle(); flushValid = 1; flushThread = 1; flushTag = 0; cycle();
    @(negedge clk); idle(); #1;
    chk(int'(dispTag) == 1, "R9 flushed entry free", int'(dispTag), 1);
    cycle();
    base = pairRetired[1];
    drain();
    chk(pairRetired[1] - base == 2, "R9 survivors retired", pairRetired[1] - base, 2);

    // constrained random traffic
    repeat (4000) begin
      int r;
      @(negedge clk); idle();
      if ($urandom % 2 == 0) begin
        dispValid = 1; dispThread = THR_W'($urandom % THREADS);
        dispSlots = 6'($urandom % 63 + 1);
      end
      for (int f = 0; f < FIN_PORTS; f++) begin
        r = $urandom % NUM_ENTRIES;
        if (mValid[r]) setFin(f, r, $urandom % 8);
      end
      if ($urandom % 40 == 0) begin
        r = $urandom % NUM_ENTRIES;
        if (mValid[r]) begin
          flushValid = 1; flushThread = THR_W'(mThr[r]); flushTag = TAG_W'(r);
        end
      end
      cycle();
    end
    drain();

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nErr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule